// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the processor-facing side of a PC-style keyboard controller. A small strobe bus (chip select, one address bit, read and write strobes, a byte-wide data bus) reaches four registers: on a read, the address bit selects between the received-byte buffer and the status byte. On a write, it selects whether the byte written counts as data or as a command. Bytes from the keyboard receiver are accepted through a valid/ready handshake into a one-byte output buffer. Bytes from the processor land in a one-byte input buffer that the rest of the controller drains with a take pulse.

Two commands are handled locally. Command 0x60 makes the next data-port write load the control byte. Command 0x20 places the control byte into the output buffer once that buffer is empty. All other commands go to the input buffer, flagged as commands. The control byte enables the keyboard interrupt, holds the system flag and controls how the external inhibit request and the keyboard disable combine into the inhibit state. The status byte merges buffer flags, the last-write kind, the inhibit state and three error flags.

Top module: `kbc_host_regs`

## Requirements
- R1: Status bit 0 (OBF) becomes 1 on the clock edge that accepts a received byte (rx_valid and rx_ready both high). A read of the data port (a2=0) returns that byte on rdata one cycle after the strobe and clears OBF on the same edge.
- R2: rx_ready is 0 while OBF is 1 or a control-byte read is pending. A byte held on rx_byte while OBF is set never replaces the byte in the buffer.
- R3: A write to the data port (a2=0) with no 0x60 pending loads the input buffer and sets ib_full and status bit 1. ib_is_cmd and status bit 3 go to 0.
- R4: A write to the command port (a2=1) of any value except 0x20 and 0x60 loads the input buffer and sets ib_full, ib_is_cmd and status bit 3 to 1.
- R5: An ib_take pulse clears ib_full and status bit 1. A buffer-loading write in the same cycle wins, leaving ib_full at 1.
- R6: Command 0x60 does not set ib_full. The next data-port write loads ctl_byte and not the input buffer. Every write sets status bit 3 to the written port's kind (1 = command port).
- R7: Command 0x20 loads ctl_byte into the output buffer on the edge after the command if OBF is clear, otherwise on the edge after OBF is cleared.
- R8: Status bit 2 (system flag) equals ctl_byte bit 3.
- R9: Status bit 4 is 0 (inhibited) when (ext_inh and not ctl_byte bit 4) or ctl_byte bit 5, and 1 otherwise, one cycle after the inputs. kb_inhibit is its complement.
- R10: Status bits 6 (receive time-out) and 7 (parity error) are captured from rx_tmo and rx_perr with each accepted byte. Both go to 0 when the control byte is loaded by command 0x20.
- R11: Status bit 5 (transmit time-out) is set by a tx_tmo pulse and cleared by a data-port write. If both occur in the same cycle, set wins.
- R12: kb_irq is 1 exactly while OBF is 1 and ctl_byte bit 0 is 1. It drops on the edge of the data-port read that empties the buffer.
- R13: After reset, rdata, ctl_byte, kb_irq and ib_full are 0, rx_ready is 1, and the status byte reads 0x10 once ext_inh has been low for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| a2 | input | 1 | Port select: 0 data, 1 command/status |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Receiver has a byte |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for this byte |
| rx_tmo | input | 1 | Receive time-out for this byte |
| rx_ready | output | 1 | Output buffer can take a byte |
| tx_tmo | input | 1 | Transmit time-out pulse |
| ext_inh | input | 1 | External inhibit request |
| kb_inhibit | output | 1 | Keyboard inhibited |
| ib_take | input | 1 | Input buffer consumed |
| ib_data | output | 8 | Input buffer contents |
| ib_is_cmd | output | 1 | Input buffer holds a command |
| ib_full | output | 1 | Input buffer full |
| ctl_byte | output | 8 | Control byte |
| kb_irq | output | 1 | Keyboard interrupt |

## Verification
The embedded assertions check four things on every cycle. A full output buffer holds its contents until a data-port read. An accepted byte appears in the buffer. A data write reaches the input buffer as data. A take with no write empties it. The interrupt is also checked to drop after an emptying read. Only the bench scenarios show the sequences that span several operations. These are the two-step control-byte write, the deferred 0x20 load behind a full buffer, the combined inhibit logic under each override and disable setting, and the capture and clearing of the error flags.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int ST_OBF  = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_SYS  = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_NINH = 4;
  localparam int ST_TTO  = 5;
  localparam int ST_RTO  = 6;
  localparam int ST_PERR = 7;

  localparam int CB_IRQEN = 0;
  localparam int CB_SYS   = 3;
  localparam int CB_OVR   = 4;
  localparam int CB_DIS   = 5;
  localparam int CB_PCM   = 6;

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic wr_data;
    logic wr_cmd;
  } kbc_evt_t;
endpackage

// File: rtl/kbc_bus_decode.sv
module kbc_bus_decode
  import kbc_pkg::*;
(
  input  logic     cs,
  input  logic     a2,
  input  logic     rd,
  input  logic     wr,
  output kbc_evt_t evt
);
  always_comb begin
    evt.rd_data = cs && rd && !a2;
    evt.rd_stat = cs && rd && a2;
    evt.wr_data = cs && wr && !a2;
    evt.wr_cmd  = cs && wr && a2;
  end
endmodule

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
  import kbc_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] CMD_RDCB = 8'h20,
  parameter logic [DW-1:0] CMD_WRCB = 8'h60,
  parameter logic [DW-1:0] CB_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  kbc_evt_t      evt,
  input  logic [DW-1:0] wdata,
  input  logic          ib_take,
  output logic [DW-1:0] ib_data,
  output logic          ib_is_cmd,
  output logic          ib_full,
  output logic          cmd_flag,
  output logic [DW-1:0] cb,
  output logic          rdcb_req
);
  logic wcb_pend;
  logic is_rdcb, is_wrcb;

  assign is_rdcb  = (wdata == CMD_RDCB);
  assign is_wrcb  = (wdata == CMD_WRCB);
  assign rdcb_req = evt.wr_cmd && is_rdcb;

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_data   <= '0;
      ib_is_cmd <= 1'b0;
      ib_full   <= 1'b0;
      cmd_flag  <= 1'b0;
      wcb_pend  <= 1'b0;
      cb        <= CB_RESET;
    end else begin
      if (ib_take) ib_full <= 1'b0;
      if (evt.wr_cmd) begin
        cmd_flag <= 1'b1;
        wcb_pend <= is_wrcb;
        if (!is_wrcb && !is_rdcb) begin
          ib_data   <= wdata;
          ib_is_cmd <= 1'b1;
          ib_full   <= 1'b1;
        end
      end else if (evt.wr_data) begin
        cmd_flag <= 1'b0;
        wcb_pend <= 1'b0;
        if (wcb_pend) begin
          cb <= wdata;
        end else begin
          ib_data   <= wdata;
          ib_is_cmd <= 1'b0;
          ib_full   <= 1'b1;
        end
      end
    end
  end

  // R3
  property data_wr_loads_chk_p;
    @(posedge clk) disable iff (rst)
      (evt.wr_data && !wcb_pend) |=> (ib_full && !ib_is_cmd && ib_data == $past(wdata));
  endproperty
  data_wr_loads_chk: assert property (data_wr_loads_chk_p);

  // R5
  property take_empties_chk_p;
    @(posedge clk) disable iff (rst)
      (ib_take && !evt.wr_data && !evt.wr_cmd) |=> !ib_full;
  endproperty
  take_empties_chk: assert property (take_empties_chk_p);
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_perr,
  input  logic          rx_tmo,
  output logic          rx_ready,
  input  logic          rd_data,
  input  logic          rdcb_req,
  input  logic [DW-1:0] cb,
  output logic [DW-1:0] obuf,
  output logic          obf,
  output logic          rto,
  output logic          perr
);
  logic pend;
  logic accept;

  assign rx_ready = !obf && !pend;
  assign accept   = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      obuf <= '0;
      obf  <= 1'b0;
      rto  <= 1'b0;
      perr <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (rd_data) obf <= 1'b0;
      if (pend && !obf) begin
        obuf <= cb;
        obf  <= 1'b1;
        rto  <= 1'b0;
        perr <= 1'b0;
        pend <= 1'b0;
      end else if (accept) begin
        obuf <= rx_byte;
        obf  <= 1'b1;
        rto  <= rx_tmo;
        perr <= rx_perr;
      end
      if (rdcb_req) pend <= 1'b1;
    end
  end

  // R2
  property full_holds_chk_p;
    @(posedge clk) disable iff (rst)
      (obf && !rd_data) |=> (obf && $stable(obuf));
  endproperty
  full_holds_chk: assert property (full_holds_chk_p);

  // R1
  property accept_fills_chk_p;
    @(posedge clk) disable iff (rst)
      accept |=> (obf && obuf == $past(rx_byte));
  endproperty
  accept_fills_chk: assert property (accept_fills_chk_p);
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] CMD_RDCB = 8'h20,
  parameter logic [DW-1:0] CMD_WRCB = 8'h60,
  parameter logic [DW-1:0] CB_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          a2,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_perr,
  input  logic          rx_tmo,
  output logic          rx_ready,
  input  logic          tx_tmo,
  input  logic          ext_inh,
  output logic          kb_inhibit,
  input  logic          ib_take,
  output logic [DW-1:0] ib_data,
  output logic          ib_is_cmd,
  output logic          ib_full,
  output logic [DW-1:0] ctl_byte,
  output logic          kb_irq
);
  kbc_evt_t      evt;
  logic [DW-1:0] obuf;
  logic          obf, rto, perr, cmd_flag, rdcb_req;
  logic          ninh, tto;
  logic [DW-1:0] status;

  kbc_bus_decode u_dec (
    .cs(cs), .a2(a2), .rd(rd), .wr(wr), .evt(evt)
  );

  kbc_in_buf #(
    .DW(DW), .CMD_RDCB(CMD_RDCB), .CMD_WRCB(CMD_WRCB), .CB_RESET(CB_RESET)
  ) u_ib (
    .clk(clk), .rst(rst), .evt(evt), .wdata(wdata), .ib_take(ib_take),
    .ib_data(ib_data), .ib_is_cmd(ib_is_cmd), .ib_full(ib_full),
    .cmd_flag(cmd_flag), .cb(ctl_byte), .rdcb_req(rdcb_req)
  );

  kbc_out_buf #(.DW(DW)) u_ob (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_tmo(rx_tmo), .rx_ready(rx_ready),
    .rd_data(evt.rd_data), .rdcb_req(rdcb_req), .cb(ctl_byte),
    .obuf(obuf), .obf(obf), .rto(rto), .perr(perr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ninh <= 1'b0;
      tto  <= 1'b0;
    end else begin
      ninh <= !((ext_inh && !ctl_byte[CB_OVR]) || ctl_byte[CB_DIS]);
      if (tx_tmo)           tto <= 1'b1;
      else if (evt.wr_data) tto <= 1'b0;
    end
  end

  assign kb_inhibit = !ninh;
  assign kb_irq     = obf && ctl_byte[CB_IRQEN];

  always_comb begin
    status          = '0;
    status[ST_OBF]  = obf;
    status[ST_IBF]  = ib_full;
    status[ST_SYS]  = ctl_byte[CB_SYS];
    status[ST_CMD]  = cmd_flag;
    status[ST_NINH] = ninh;
    status[ST_TTO]  = tto;
    status[ST_RTO]  = rto;
    status[ST_PERR] = perr;
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (evt.rd_data) rdata <= obuf;
    else if (evt.rd_stat) rdata <= status;
  end

  // R12
  property irq_drops_chk_p;
    @(posedge clk) disable iff (rst)
      (evt.rd_data && obf) |=> !kb_irq;
  endproperty
  irq_drops_chk: assert property (irq_drops_chk_p);
endmodule

// File: tb/sim_kbc_host_regs.sv
`timescale 1ns/1ps
module sim_kbc_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, a2 = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       rx_valid = 0, rx_perr = 0, rx_tmo = 0;
  logic [7:0] rx_byte = 0;
  logic       rx_ready;
  logic       tx_tmo = 0, ext_inh = 0, ib_take = 0;
  logic       kb_inhibit, ib_is_cmd, ib_full, kb_irq;
  logic [7:0] ib_data, ctl_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbc_host_regs u0 (
    .clk(clk), .rst(rst), .cs(cs), .a2(a2), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr),
    .rx_tmo(rx_tmo), .rx_ready(rx_ready), .tx_tmo(tx_tmo), .ext_inh(ext_inh),
    .kb_inhibit(kb_inhibit), .ib_take(ib_take), .ib_data(ib_data),
    .ib_is_cmd(ib_is_cmd), .ib_full(ib_full), .ctl_byte(ctl_byte), .kb_irq(kb_irq)
  );

  function automatic logic [7:0] st(input logic obf, ibf, sys, cmd, ninh, tto, rto, pe);
    return {pe, rto, tto, ninh, cmd, sys, ibf, obf};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic cpu_wr(input logic port, input logic [7:0] v);
    cs = 1; wr = 1; a2 = port; wdata = v;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic cpu_rd(input logic port, output logic [7:0] v);
    cs = 1; rd = 1; a2 = port;
    @(negedge clk);
    cs = 0; rd = 0;
    v = rdata;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic pe, input logic to);
    rx_valid = 1; rx_byte = b; rx_perr = pe; rx_tmo = to;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0; rx_perr = 0; rx_tmo = 0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] b;
    logic pe, to, m_ibf, m_cmd, m_tto;
    void'($urandom(32'd20250));
    repeat (4) tick();
    rst = 0;
    // R13 reset state
    check("R13 rdata", rdata, 8'h00);
    check("R13 ctl_byte", ctl_byte, 8'h00);
    check("R13 irq/ibf/ready", {kb_irq, ib_full, rx_ready}, 3'b001);
    tick();
    cpu_rd(1, v); check("R13 status", v, 8'h10);

    // R1 receive and read
    rx_send(8'hA5, 0, 0);
    check("R2 ready low when full", rx_ready, 0);
    cpu_rd(1, v); check("R1 obf set", v, 8'h11);
    cpu_rd(0, v); check("R1 data", v, 8'hA5);
    cpu_rd(1, v); check("R1 obf cleared", v, 8'h10);

    // R2 hold-off
    rx_send(8'h11, 0, 0);
    rx_valid = 1; rx_byte = 8'h22;
    repeat (3) tick();
    check("R2 held off", rx_ready, 0);
    cpu_rd(0, v); check("R2 no overwrite", v, 8'h11);
    tick(); rx_valid = 0;
    cpu_rd(0, v); check("R2 second byte", v, 8'h22);

    // R3 data write
    cpu_wr(0, 8'h5A);
    check("R3 ib", {ib_full, ib_is_cmd}, 2'b10);
    check("R3 ib_data", ib_data, 8'h5A);
    cpu_rd(1, v); check("R3 status", v, 8'h12);
    ib_take = 1; tick(); ib_take = 0;
    check("R5 take clears", ib_full, 0);
    ib_take = 1; cpu_wr(1, 8'hAB); ib_take = 0;
    check("R5 write wins / R4 cmd", {ib_full, ib_is_cmd}, 2'b11);
    cpu_rd(1, v); check("R4 status", v, 8'h1A);
    ib_take = 1; tick(); ib_take = 0;

    // R6 control byte write
    cpu_wr(1, 8'h60);
    check("R6 no ibf on 0x60", ib_full, 0);
    cpu_wr(0, 8'h09);
    check("R6 ctl_byte", ctl_byte, 8'h09);
    check("R6 ibf stays 0", ib_full, 0);
    cpu_rd(1, v); check("R8 sys flag", v, 8'h14);

    // R12 interrupt
    rx_send(8'h77, 0, 0);
    check("R12 irq high", kb_irq, 1);
    cpu_rd(0, v); check("R12 data", v, 8'h77);
    check("R12 irq low", kb_irq, 0);

    // R7 control byte read
    cpu_wr(1, 8'h20); tick();
    cpu_rd(0, v); check("R7 read cb", v, 8'h09);
    rx_send(8'h44, 0, 0);
    cpu_wr(1, 8'h20); tick(); tick();
    check("R2 ready low pending", rx_ready, 0);
    cpu_rd(0, v); check("R7 byte first", v, 8'h44);
    tick();
    cpu_rd(0, v); check("R7 deferred cb", v, 8'h09);

    // R9 inhibit
    ext_inh = 1; tick(); tick();
    cpu_rd(1, v); check("R9 inhibited", v, 8'h0C);
    check("R9 kb_inhibit", kb_inhibit, 1);
    cpu_wr(1, 8'h60); cpu_wr(0, 8'h19); tick();
    cpu_rd(1, v); check("R9 override", v, 8'h14);
    ext_inh = 0;
    cpu_wr(1, 8'h60); cpu_wr(0, 8'h29); tick();
    cpu_rd(1, v); check("R9 disable", v, 8'h04);
    check("R9 kb_inhibit dis", kb_inhibit, 1);

    // R10 error flags
    cpu_wr(1, 8'h60); cpu_wr(0, 8'h08); tick();
    rx_send(8'h55, 1, 1);
    check("R12 irq disabled", kb_irq, 0);
    cpu_rd(1, v); check("R10 flags captured", v, 8'hD5);
    cpu_rd(0, v); check("R10 data", v, 8'h55);
    cpu_rd(1, v); check("R10 flags persist", v, 8'hD4);
    cpu_wr(1, 8'h20); tick();
    cpu_rd(1, v); check("R10 flags cleared", v, 8'h1D);
    cpu_rd(0, v); check("R7 cb 08", v, 8'h08);

    // R11 transmit time-out
    tx_tmo = 1; tick(); tx_tmo = 0;
    cpu_rd(1, v); check("R11 set", v, 8'h3C);
    cpu_wr(0, 8'h33);
    cpu_rd(1, v); check("R11 cleared", v, 8'h16);
    tx_tmo = 1; cpu_wr(0, 8'h34); tx_tmo = 0;
    cpu_rd(1, v); check("R11 set wins", v, 8'h36);
    cpu_wr(0, 8'h35);
    ib_take = 1; tick(); ib_take = 0;
    cpu_rd(1, v); check("R11 clear again", v, 8'h14);

    // Random mix
    m_ibf = 0; m_cmd = 0; m_tto = 0;
    for (int i = 0; i < 40; i++) begin
      b = 8'($urandom); pe = 1'($urandom); to = 1'($urandom);
      if ($urandom % 2 == 0) begin
        cpu_wr(0, b ^ 8'hFF);
        m_ibf = 1; m_cmd = 0; m_tto = 0;
        check("R3 random ib_data", ib_data, b ^ 8'hFF);
      end
      if ($urandom % 3 == 0) begin
        ib_take = 1; tick(); ib_take = 0; m_ibf = 0;
      end
      rx_send(b, pe, to);
      cpu_rd(1, v);
      check("R1/R10 random status", v, st(1, m_ibf, 1, m_cmd, 1, m_tto, to, pe));
      cpu_rd(0, v);
      check("R1 random data", v, b);
    end
    finish_up();
  end
endmodule